// File: doc/BRIEF.md
# System Watchdog and Bus Monitor

This block guards a processor subsystem in two ways. A software watchdog counts system clocks while enabled, and software must service it before the count reaches the programmed period. Servicing means writing a two-byte key to the service location in the right order. When the count expires, the watchdog does one of two things, chosen by a control bit. It either sends a single-cycle system reset pulse or raises an interrupt request. The interrupt request carries a programmable 8-bit vector. A status register records whether the last reset came from the hard reset input or from the watchdog.

The bus monitor shares the control register. It counts the clocks of each outstanding bus cycle, from a start strobe to a terminate strobe. If no termination arrives within the selected limit, it emits a one-cycle timeout pulse, which the surrounding logic uses to end the cycle with an error. Two configuration bits let a debug freeze input halt either counter. Software uses a four-location byte register port: control, freeze configuration, vector, and service writes or status reads.

Top module: `sysprot_unit`

## Requirements
- R1: After reset the control and freeze registers read 0x00, the vector reads 0x0F, and status reads 0x02 (bit 1 hard-reset flag = 1, bit 0 watchdog flag = 0); all outputs are low.
- R2: Register addresses are 0 control, 1 freeze config (bits 1:0), 2 vector, 3 service (write) / status (read). Control bits: 7 watchdog enable, 6 expiry action (1 interrupt, 0 reset), 5 prescaler, 4:3 watchdog timing, 2 bus monitor enable, 1:0 bus monitor timing. Unused freeze bits read 0.
- R3: An enabled watchdog expires after 2^(B+2*t) counted clocks, where t is the timing field. With the prescaler set it is 2^(B+P+2*t). The defaults B=9 and P=9 give 512 to 32768 clocks, or 2^18 to 2^24 clocks with the prescaler. The count starts from the edge that enables it or that completes a service.
- R4: Writing 0x55 and then 0xAA to address 3 restarts the watchdog count from zero and clears a pending interrupt request.
- R5: Any service write that is not the expected next key returns the sequence to waiting for 0x55 and does not restart the count; a second 0x55 also counts as a wrong key.
- R6: Expiry in reset mode drives wd_rst_o high for exactly one cycle and sets status to 0x01 (watchdog flag set, hard flag cleared); the count restarts from zero.
- R7: Expiry in interrupt mode sets wd_irq_o, which stays high until a complete service; wd_vec_o always shows the vector register.
- R8: With the watchdog enable clear the count is held at zero and no reset or new interrupt is produced.
- R9: An enabled bus monitor pulses bm_timeout_o 1024 >> c clocks after a bus-cycle start, where c is its timing field (1024, 512, 256 or 128 at the default BM_MAX_LOG2=10). While it is disabled it never times out.
- R10: A terminate clears the bus count. The count runs only while a cycle is outstanding. A start together with a terminate begins a new cycle. The timeout is a one-cycle pulse that also ends the outstanding cycle.
- R11: While dbg_freeze_i is high, freeze bit 1 holds the watchdog count and freeze bit 0 holds the bus count. With a bit clear, the freeze input has no effect on that counter.
- R12: A service completing on the same edge the watchdog would expire wins: no reset or interrupt is produced and a full period restarts.
- R13: Writes to address 3 never alter the status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous hard reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| bus_start_i | input | 1 | Bus cycle begins |
| bus_term_i | input | 1 | Bus cycle terminated |
| dbg_freeze_i | input | 1 | Debug freeze request |
| wd_rst_o | output | 1 | Watchdog system reset pulse |
| wd_irq_o | output | 1 | Watchdog interrupt request |
| wd_vec_o | output | 8 | Interrupt vector |
| bm_timeout_o | output | 1 | Bus monitor timeout pulse |

## Verification
The bench aims at edges where two things happen at once. One is a service that completes on the exact expiry edge: a design that checks expiry first would fire a reset that software had just prevented. Another is a repeated 0x55 followed by 0xAA: a design that stays armed after a second 0x55 would accept a broken key pair. A third is a bus start together with a terminate: a design that let the terminate win outright would never time out the new cycle. Freeze is tried with its configuration bit both set and clear. A design that holds the count on any freeze would stretch the watchdog period, and one that ignores the bit would shorten it.

// File: rtl/sysprot_pkg.sv
package sysprot_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_FRZ  = 2'd1;
  localparam logic [1:0] ADDR_VEC  = 2'd2;
  localparam logic [1:0] ADDR_SVC  = 2'd3;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
  localparam logic [7:0] VEC_RST    = 8'h0F;

  typedef struct packed {
    logic       wd_en;
    logic       wd_irq;
    logic       wd_pre;
    logic [1:0] wd_sel;
    logic       bm_en;
    logic [1:0] bm_sel;
  } ctrl_t;

  typedef enum logic {KEY_IDLE, KEY_ARMED} key_st_e;
endpackage

// File: rtl/sysprot_regs.sv
module sysprot_regs
  import sysprot_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       wd_fired_i,
  output ctrl_t      ctrl_o,
  output logic [1:0] frz_o,
  output logic [7:0] vec_o,
  output logic [1:0] rst_stat_o,
  output logic       svc_wr_o,
  output logic [7:0] rdata_o
);
  ctrl_t      ctrl_q;
  logic [1:0] frz_q;
  logic [7:0] vec_q;
  logic       hard_q, wdf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      frz_q  <= '0;
      vec_q  <= VEC_RST;
    end else if (we_i) begin
      case (addr_i)
        ADDR_CTRL: ctrl_q <= ctrl_t'(wdata_i);
        ADDR_FRZ:  frz_q  <= wdata_i[1:0];
        ADDR_VEC:  vec_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  // status flags: hard reset sets hard, watchdog expiry swaps them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hard_q <= 1'b1;
      wdf_q  <= 1'b0;
    end else if (wd_fired_i) begin
      hard_q <= 1'b0;
      wdf_q  <= 1'b1;
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_q;
      ADDR_FRZ:  rdata_o = {6'b0, frz_q};
      ADDR_VEC:  rdata_o = vec_q;
      default:   rdata_o = {6'b0, hard_q, wdf_q};
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign frz_o      = frz_q;
  assign vec_o      = vec_q;
  assign rst_stat_o = {hard_q, wdf_q};
  assign svc_wr_o   = we_i && (addr_i == ADDR_SVC);
endmodule

// File: rtl/sysprot_key.sv
module sysprot_key
  import sysprot_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       svc_wr_i,
  input  logic [7:0] wdata_i,
  output logic       kick_o
);
  key_st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      st_q <= KEY_IDLE;
    else if (svc_wr_i)
      st_q <= (st_q == KEY_IDLE && wdata_i == KEY_FIRST) ? KEY_ARMED : KEY_IDLE;
  end

  assign kick_o = svc_wr_i && (st_q == KEY_ARMED) && (wdata_i == KEY_SECOND);
endmodule

// File: rtl/sysprot_wdog.sv
module sysprot_wdog #(
  parameter int WD_BASE_LOG2 = 9,
  parameter int WD_PRE_LOG2  = 9,
  localparam int CW  = WD_BASE_LOG2 + WD_PRE_LOG2 + 6,
  localparam int SHW = $clog2(CW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          irq_mode_i,
  input  logic          pre_i,
  input  logic [1:0]    sel_i,
  input  logic          hold_i,
  input  logic          kick_i,
  output logic          rst_o,
  output logic          irq_o,
  output logic          fire_rst_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0]  cnt_q, lim;
  logic [SHW-1:0] sh;
  logic           run, expire;

  assign sh     = SHW'(WD_BASE_LOG2) + (pre_i ? SHW'(WD_PRE_LOG2) : '0) + SHW'({sel_i, 1'b0});
  assign lim    = (ONE << sh) - ONE;
  assign run    = en_i && !hold_i;
  assign expire = run && !kick_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (kick_i || !en_i)   cnt_q <= '0;
    else if (expire)            cnt_q <= '0;
    else if (run)               cnt_q <= cnt_q + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      rst_o <= expire && !irq_mode_i;
      if (kick_i)                  irq_o <= 1'b0;
      else if (expire && irq_mode_i) irq_o <= 1'b1;
    end
  end

  assign fire_rst_o = expire && !irq_mode_i;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/sysprot_busmon.sv
module sysprot_busmon #(
  parameter int BM_MAX_LOG2 = 10,
  localparam int BW  = BM_MAX_LOG2,
  localparam int SBW = $clog2(BW + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] sel_i,
  input  logic       hold_i,
  input  logic       start_i,
  input  logic       term_i,
  output logic       timeout_o,
  output logic       busy_o
);
  localparam logic [BW-1:0] ONE = BW'(1);

  logic [BW-1:0]  cnt_q, lim;
  logic [SBW-1:0] sh;
  logic           busy_q, expire;

  assign sh     = SBW'(BM_MAX_LOG2) - SBW'(sel_i);
  assign lim    = (ONE << sh) - ONE;
  assign expire = busy_q && !term_i && en_i && !hold_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (term_i || !busy_q) begin
      cnt_q  <= '0;
      busy_q <= start_i;
    end else if (!en_i) begin
      cnt_q  <= '0;
    end else if (expire) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (!hold_i) begin
      cnt_q  <= cnt_q + ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) timeout_o <= 1'b0;
    else         timeout_o <= expire;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/sysprot_unit.sv
module sysprot_unit
  import sysprot_pkg::*;
#(
  parameter int WD_BASE_LOG2 = 9,
  parameter int WD_PRE_LOG2  = 9,
  parameter int BM_MAX_LOG2  = 10,
  localparam int WD_CW = WD_BASE_LOG2 + WD_PRE_LOG2 + 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       bus_start_i,
  input  logic       bus_term_i,
  input  logic       dbg_freeze_i,
  output logic       wd_rst_o,
  output logic       wd_irq_o,
  output logic [7:0] wd_vec_o,
  output logic       bm_timeout_o
);
  ctrl_t            ctrl;
  logic [1:0]       frz, rst_stat;
  logic             svc_wr, kick, wd_fired, wd_hold, bm_hold, bm_busy;
  logic [WD_CW-1:0] wd_cnt;

  assign wd_hold = dbg_freeze_i && frz[1];
  assign bm_hold = dbg_freeze_i && frz[0];

  sysprot_regs i_regs (
    .clk_i, .rst_ni,
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .wd_fired_i (wd_fired),
    .ctrl_o     (ctrl),
    .frz_o      (frz),
    .vec_o      (wd_vec_o),
    .rst_stat_o (rst_stat),
    .svc_wr_o   (svc_wr),
    .rdata_o    (reg_rdata_o)
  );

  sysprot_key i_key (
    .clk_i, .rst_ni,
    .svc_wr_i (svc_wr),
    .wdata_i  (reg_wdata_i),
    .kick_o   (kick)
  );

  sysprot_wdog #(.WD_BASE_LOG2(WD_BASE_LOG2), .WD_PRE_LOG2(WD_PRE_LOG2)) i_wdog (
    .clk_i, .rst_ni,
    .en_i       (ctrl.wd_en),
    .irq_mode_i (ctrl.wd_irq),
    .pre_i      (ctrl.wd_pre),
    .sel_i      (ctrl.wd_sel),
    .hold_i     (wd_hold),
    .kick_i     (kick),
    .rst_o      (wd_rst_o),
    .irq_o      (wd_irq_o),
    .fire_rst_o (wd_fired),
    .cnt_o      (wd_cnt)
  );

  sysprot_busmon #(.BM_MAX_LOG2(BM_MAX_LOG2)) i_busmon (
    .clk_i, .rst_ni,
    .en_i      (ctrl.bm_en),
    .sel_i     (ctrl.bm_sel),
    .hold_i    (bm_hold),
    .start_i   (bus_start_i),
    .term_i    (bus_term_i),
    .timeout_o (bm_timeout_o),
    .busy_o    (bm_busy)
  );
endmodule

// File: rtl/sysprot_chk.sv
module sysprot_chk #(
  parameter int CW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          kick,
  input logic          wd_en,
  input logic          wd_hold,
  input logic [CW-1:0] wd_cnt,
  input logic [1:0]    rst_stat,
  input logic          wd_rst_o,
  input logic          wd_irq_o,
  input logic          bm_timeout_o,
  input logic          bm_busy
);
  p_kick_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick |=> (wd_cnt == '0) && !wd_irq_o);

  p_rst_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_rst_o |=> !wd_rst_o);

  p_rst_status_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_rst_o |-> (rst_stat == 2'b01));

  p_irq_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_irq_o && !kick) |=> wd_irq_o);

  p_off_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wd_en |=> !wd_rst_o && (wd_cnt == '0));

  p_freeze_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_en && wd_hold && !kick) |=> $stable(wd_cnt));

  p_bm_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bm_timeout_o |=> !bm_timeout_o);

  p_bm_ends_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bm_timeout_o |-> !bm_busy);
endmodule

bind sysprot_unit sysprot_chk #(.CW(WD_CW)) i_sysprot_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .kick         (kick),
  .wd_en        (ctrl.wd_en),
  .wd_hold      (wd_hold),
  .wd_cnt       (wd_cnt),
  .rst_stat     (rst_stat),
  .wd_rst_o     (wd_rst_o),
  .wd_irq_o     (wd_irq_o),
  .bm_timeout_o (bm_timeout_o),
  .bm_busy      (bm_busy)
);

// File: tb/test_sysprot_unit.sv
module test_sysprot_unit;
  localparam int WB = 4;
  localparam int WP = 3;
  localparam int BM = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       bus_start = 1'b0, bus_term = 1'b0, frz_in = 1'b0;
  logic [7:0] reg_rdata, wd_vec;
  logic       wd_rst, wd_irq, bm_to;

  always #2 clk = ~clk;

  sysprot_unit #(.WD_BASE_LOG2(WB), .WD_PRE_LOG2(WP), .BM_MAX_LOG2(BM)) i_sysprot_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .bus_start_i(bus_start), .bus_term_i(bus_term), .dbg_freeze_i(frz_in),
    .wd_rst_o(wd_rst), .wd_irq_o(wd_irq), .wd_vec_o(wd_vec), .bm_timeout_o(bm_to)
  );

  int n_cmp = 0, n_bad = 0, n_rst = 0, n_bto = 0;

  // behavioural reference model
  logic [7:0] m_ctrl = 8'h00, m_vec = 8'h0F;
  logic [1:0] m_frz = 2'b00;
  logic       m_hard = 1'b1, m_wdf = 1'b0, m_key = 1'b0, m_irq = 1'b0, m_rst = 1'b0;
  logic       m_busy = 1'b0, m_bto = 1'b0, m_kick;
  longint     m_wcnt = 0, m_bcnt = 0, per, blim;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 8'h00; m_vec = 8'h0F; m_frz = 2'b00; m_hard = 1'b1; m_wdf = 1'b0;
      m_key = 1'b0; m_irq = 1'b0; m_rst = 1'b0; m_busy = 1'b0; m_bto = 1'b0;
      m_wcnt = 0; m_bcnt = 0;
    end else begin
      m_kick = reg_we && reg_addr == 2'd3 && reg_wdata == 8'hAA && m_key;
      if (reg_we && reg_addr == 2'd3) m_key = (!m_key && reg_wdata == 8'h55);
      per = longint'(1) << (WB + (m_ctrl[5] ? WP : 0) + 2 * int'(m_ctrl[4:3]));
      m_rst = 1'b0;
      if (m_kick) begin m_wcnt = 0; m_irq = 1'b0; end
      else if (!m_ctrl[7]) m_wcnt = 0;
      else if (!(frz_in && m_frz[1])) begin
        if (m_wcnt >= per - 1) begin
          m_wcnt = 0;
          if (m_ctrl[6]) m_irq = 1'b1;
          else begin m_rst = 1'b1; m_hard = 1'b0; m_wdf = 1'b1; end
        end else m_wcnt++;
      end
      blim = longint'(1) << (BM - int'(m_ctrl[1:0]));
      m_bto = 1'b0;
      if (bus_term || !m_busy) begin m_bcnt = 0; m_busy = bus_start; end
      else if (!m_ctrl[2]) m_bcnt = 0;
      else if (!(frz_in && m_frz[0])) begin
        if (m_bcnt >= blim - 1) begin m_bto = 1'b1; m_bcnt = 0; m_busy = 1'b0; end
        else m_bcnt++;
      end
      if (reg_we) begin
        case (reg_addr)
          2'd0: m_ctrl = reg_wdata;
          2'd1: m_frz = reg_wdata[1:0];
          2'd2: m_vec = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [7:0] m_rdata();
    case (reg_addr)
      2'd0: return m_ctrl;
      2'd1: return {6'b0, m_frz};
      2'd2: return m_vec;
      default: return {6'b0, m_hard, m_wdf};
    endcase
  endfunction

  task automatic compare_all();
    if (rst_n) begin
      chk("R6 wd_rst_o", wd_rst, m_rst);
      chk("R7 wd_irq_o", wd_irq, m_irq);
      chk("R7 wd_vec_o", wd_vec, m_vec);
      chk("R9 bm_timeout_o", bm_to, m_bto);
      chk("R2 reg_rdata_o", reg_rdata, m_rdata());
    end
    if (wd_rst) n_rst++;
    if (bm_to) n_bto++;
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [7:0] d,
                      input logic s, input logic t, input logic f);
    reg_we = we; reg_addr = a; reg_wdata = d; bus_start = s; bus_term = t; frz_in = f;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [1:0] a);
    step(1'b0, a, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
  end

  int base;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0); chk("R1 ctrl", reg_rdata, 8'h00);
    chk("R1 outputs", {wd_rst, wd_irq, bm_to}, 3'b000);
    rd(2'd1); chk("R1 freeze", reg_rdata, 8'h00);
    rd(2'd2); chk("R1 vector", reg_rdata, 8'h0F);
    rd(2'd3); chk("R1 status", reg_rdata, 8'h02);

    // R3 / R6 reset mode, period 16
    wr(2'd0, 8'h80);
    idle(15); chk("R3 no early reset", wd_rst, 1'b0);
    idle(1);  chk("R6 reset pulse", wd_rst, 1'b1);
    idle(1);  chk("R6 pulse one cycle", wd_rst, 1'b0);
    rd(2'd3); chk("R6 status", reg_rdata, 8'h01);
    wr(2'd3, 8'h02);
    rd(2'd3); chk("R13 status unchanged", reg_rdata, 8'h01);

    // R8 disabled
    wr(2'd0, 8'h00);
    base = n_rst;
    idle(40); chk("R8 no reset while disabled", n_rst - base, 0);

    // R4 regular servicing, period 64
    wr(2'd0, 8'h88);
    base = n_rst;
    for (int k = 0; k < 5; k++) begin idle(30); wr(2'd3, 8'h55); wr(2'd3, 8'hAA); end
    chk("R4 serviced no reset", n_rst - base, 0);
    idle(63); chk("R4 restart full period", wd_rst, 1'b0);
    idle(1);  chk("R4 expiry after period", wd_rst, 1'b1);

    // R5 wrong keys
    wr(2'd3, 8'h55); wr(2'd3, 8'h12); wr(2'd3, 8'hAA);
    idle(60); chk("R5 before expiry", wd_rst, 1'b0);
    idle(1);  chk("R5 bad key no reload", wd_rst, 1'b1);
    wr(2'd3, 8'h55); wr(2'd3, 8'h55); wr(2'd3, 8'hAA);
    idle(60); chk("R5 before expiry", wd_rst, 1'b0);
    idle(1);  chk("R5 double first key rejected", wd_rst, 1'b1);

    // R12 service on the expiry edge
    wr(2'd3, 8'h55); wr(2'd3, 8'hAA);
    idle(62);
    wr(2'd3, 8'h55); wr(2'd3, 8'hAA);
    chk("R12 service beats expiry", wd_rst, 1'b0);
    idle(63); chk("R12 full period restarted", wd_rst, 1'b0);
    idle(1);  chk("R12 next expiry", wd_rst, 1'b1);

    // R7 interrupt mode
    wr(2'd2, 8'hA5); chk("R7 vector output", wd_vec, 8'hA5);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'hC0);
    idle(15); chk("R7 no early irq", wd_irq, 1'b0);
    idle(1);  chk("R7 irq raised", {wd_irq, wd_rst}, 2'b10);
    idle(40); chk("R7 irq held", wd_irq, 1'b1);
    wr(2'd3, 8'h55); chk("R7 half key keeps irq", wd_irq, 1'b1);
    wr(2'd3, 8'hAA); chk("R4 service clears irq", wd_irq, 1'b0);

    // R3 prescaler, period 128
    wr(2'd0, 8'h00);
    wr(2'd0, 8'hA0);
    idle(127); chk("R3 prescaled before", wd_rst, 1'b0);
    idle(1);   chk("R3 prescaled expiry", wd_rst, 1'b1);
    wr(2'd0, 8'h00);

    // R11 freeze on watchdog
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h80);
    idle(5);
    for (int k = 0; k < 4; k++) step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1);
    idle(10); chk("R11 frozen delays expiry", wd_rst, 1'b0);
    idle(1);  chk("R11 expiry after freeze", wd_rst, 1'b1);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h80);
    for (int k = 0; k < 4; k++) step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1);
    idle(11); chk("R11 freeze ignored before", wd_rst, 1'b0);
    idle(1);  chk("R11 freeze ignored expiry", wd_rst, 1'b1);
    wr(2'd0, 8'h00);

    // R2 readback
    wr(2'd0, 8'h5A); rd(2'd0); chk("R2 ctrl readback", reg_rdata, 8'h5A);
    wr(2'd1, 8'hFF); rd(2'd1); chk("R2 freeze readback", reg_rdata, 8'h03);
    rd(2'd2); chk("R2 vector readback", reg_rdata, 8'hA5);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);

    // R9 bus monitor limits
    for (int c = 0; c < 4; c++) begin
      wr(2'd0, 8'h04 | 8'(c));
      step(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0);
      idle((1024 >> c) - 1); chk("R9 no early timeout", bm_to, 1'b0);
      idle(1); chk("R9 timeout", bm_to, 1'b1);
      idle(1); chk("R10 one-cycle pulse", bm_to, 1'b0);
    end

    // R10 termination and overlap
    step(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0);
    idle(100);
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0);
    base = n_bto;
    idle(200); chk("R10 terminated and idle", n_bto - base, 0);
    step(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0);
    idle(50);
    step(1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0);
    idle(127); chk("R10 restart on start+term", bm_to, 1'b0);
    idle(1);   chk("R10 new cycle timeout", bm_to, 1'b1);

    // R11 freeze on bus monitor
    wr(2'd1, 8'h01);
    step(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0);
    idle(10);
    for (int k = 0; k < 5; k++) step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1);
    idle(117); chk("R11 bus frozen", bm_to, 1'b0);
    idle(1);   chk("R11 bus expiry after freeze", bm_to, 1'b1);

    // R9 disabled monitor
    wr(2'd0, 8'h00);
    step(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0);
    base = n_bto;
    idle(1100); chk("R9 disabled never times out", n_bto - base, 0);

    summary();
  end
endmodule